// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-mapped master for the two-wire PHY management bus (IEEE 802.3 Clause 22). Software programs a clock divider and an enable bit. It then writes a command that holds a PHY address, a register address, a read/write selector and an initiate bit. The block derives the management clock from the host clock. It sends a 32-bit preamble and the frame, turns the data line around on reads, and returns the 16 bits it captures through a read-data register. A ready flag in the command register tells software when a new command may be issued.

The data line is a tri-state pin, so the block presents it as an output value, an output enable and an input. Internally there are three parts: a clock generator that produces the management clock and its edge strobes, a frame engine that shifts bits and captures read data, and the register file in the top module.

Top module: `mdio_master`

## Requirements
- R1: While enabled, the management clock has a period of 2*(div+1) host clock cycles, where div is the divider field in bits [DIV_W-1:0] of the control register (address 0).
- R2: While the enable bit (control register bit 16) is zero, the management clock is held low.
- R3: A command register (address 1) write with bit 16 (initiate) set, accepted while ready, sends one frame. The frame is 32 ones, then 01, then the opcode (10 read, 01 write), the PHY address from bits [4:0] MSB first, the register address from bits [12:8] MSB first, the turnaround, and 16 data bits MSB first. Bit 15 of the command register selects read (1) or write (0).
- R4: The ready flag (command register bit 17) reads zero from the cycle after an accepted initiate until the frame is complete, and reads one afterwards. When no frame is in progress, the output enable is low.
- R5: Write data (address 2, bits [15:0]) is taken when the first preamble bit is driven. Changing that register later has no effect on the frame in progress.
- R6: On a read, the data line is released from the turnaround onward. Data is sampled as the management clock rises, and the 16 captured bits appear in bits [15:0] of the read-data register (address 3).
- R7: On a write, the turnaround is driven as 10. The driven data line changes only together with a falling management clock edge.
- R8: A command register write while ready is zero is ignored completely: the fields keep their values and no extra frame follows.
- R9: An initiate accepted while the enable bit is zero stays pending. Ready stays low and no clock runs until the block is enabled, and the frame then completes.
- R10: After reset the enable bit and divider read zero, ready reads one, the management clock is low and the data line is released.
- R11: The divider field is DIV_W bits wide. Higher written bits are dropped, so the field reads back truncated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered one cycle after the address |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
A wrong divider count or a stuck enable shows up on the management clock within one period, because the bench compares that pin with a reference model on every host clock. A wrong bit counter or shift state shows up at the end of the frame as a corrupted bit, a misplaced turnaround or an output enable at the wrong time, as seen by a bench PHY that records every rising edge. A wrong busy state shows up in the ready flag one cycle after initiate, or as a frame that never finishes before the poll limit.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_LEN = 64;
  localparam int TA_POS    = 46;
  localparam int DATA_POS  = 48;
  localparam int IDX_W     = $clog2(FRAME_LEN + 1);

  localparam logic [1:0] REG_CTRL  = 2'd0;
  localparam logic [1:0] REG_CMD   = 2'd1;
  localparam logic [1:0] REG_WDATA = 2'd2;
  localparam logic [1:0] REG_RDATA = 2'd3;

  localparam int EN_BIT    = 16;
  localparam int RD_BIT    = 15;
  localparam int INIT_BIT  = 16;
  localparam int READY_BIT = 17;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise,
  output logic             fall
);
  logic [DIV_W-1:0] cnt;
  logic             tick;

  assign tick = en && (cnt >= div);
  assign rise = tick && !mdc;
  assign fall = tick && mdc;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (cnt >= div) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R2: a disabled generator parks the clock low
  p_mdc_parked_r2: assert property (@(posedge clk) disable iff (rst)
    !en |=> !mdc);
  // R1: the clock moves only on a terminal count
  p_mdc_moves_on_tick_r1: assert property (@(posedge clk) disable iff (rst)
    (en && !rise && !fall) |=> $stable(mdc));
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        rd_req,
  input  logic [4:0]  phy,
  input  logic [4:0]  regad,
  input  logic [15:0] wdata,
  input  logic        rise,
  input  logic        fall,
  input  logic        mdio_i,
  output logic        busy,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        done,
  output logic        is_read,
  output logic [15:0] rx
);
  logic [IDX_W-1:0]     idx;
  logic [FRAME_LEN-1:0] sh;
  logic [FRAME_LEN-1:0] frame;

  assign frame = {32'hFFFF_FFFF, 2'b01,
                  is_read ? 2'b10 : 2'b01, phy, regad,
                  is_read ? 2'b11 : 2'b10,
                  is_read ? 16'hFFFF : wdata};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      is_read <= 1'b0;
      idx     <= '0;
      sh      <= '0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      done    <= 1'b0;
      rx      <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy    <= 1'b1;
        is_read <= rd_req;
        idx     <= '0;
      end
      if (busy && fall) begin
        if (idx == IDX_W'(FRAME_LEN)) begin
          busy    <= 1'b0;
          idx     <= '0;
          mdio_oe <= 1'b0;
          mdio_o  <= 1'b1;
          done    <= 1'b1;
        end else begin
          if (idx == '0) begin
            mdio_o <= frame[FRAME_LEN-1];
            sh     <= {frame[FRAME_LEN-2:0], 1'b0};
          end else begin
            mdio_o <= sh[FRAME_LEN-1];
            sh     <= {sh[FRAME_LEN-2:0], 1'b0};
          end
          mdio_oe <= !(is_read && (idx >= IDX_W'(TA_POS)));
          idx     <= idx + 1'b1;
        end
      end
      if (busy && rise && is_read && (idx > IDX_W'(DATA_POS)))
        rx <= {rx[14:0], mdio_i};
    end
  end

  // R4: the line is never driven outside a frame
  p_idle_released_r4: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdio_oe);
  // R6: released from the turnaround on during reads
  p_read_released_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && is_read && idx > IDX_W'(TA_POS)) |-> !mdio_oe);
  // R7: driven value changes only with a falling clock strobe
  p_change_on_fall_r7: assert property (@(posedge clk) disable iff (rst)
    !fall |=> $stable(mdio_o));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W = 6
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  bus_addr,
  input  logic        bus_we,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic             en;
  logic [DIV_W-1:0] div;
  logic [4:0]       phy, regad;
  logic             rd_sel;
  logic [15:0]      wdata_q, rdata_q, rx;
  logic             rise, fall, busy, done, start, is_read, cmd_wr;
  logic             unused_bits;

  assign unused_bits = ^{bus_wdata[31:18], bus_wdata[14:13], bus_wdata[7:5]};
  assign cmd_wr = bus_we && (bus_addr == REG_CMD) && !busy;
  assign start  = cmd_wr && bus_wdata[INIT_BIT];

  mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst(rst), .en(en), .div(div),
    .mdc(mdc), .rise(rise), .fall(fall));

  mdio_frame u_frame (
    .clk(clk), .rst(rst), .start(start), .rd_req(bus_wdata[RD_BIT]),
    .phy(phy), .regad(regad), .wdata(wdata_q), .rise(rise), .fall(fall),
    .mdio_i(mdio_i), .busy(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .done(done), .is_read(is_read), .rx(rx));

  always_ff @(posedge clk) begin
    if (rst) begin
      en      <= 1'b0;
      div     <= '0;
      phy     <= '0;
      regad   <= '0;
      rd_sel  <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (bus_we && bus_addr == REG_CTRL) begin
        en  <= bus_wdata[EN_BIT];
        div <= bus_wdata[DIV_W-1:0];
      end
      if (cmd_wr) begin
        phy    <= bus_wdata[4:0];
        regad  <= bus_wdata[12:8];
        rd_sel <= bus_wdata[RD_BIT];
      end
      if (bus_we && bus_addr == REG_WDATA)
        wdata_q <= bus_wdata[15:0];
      if (done && is_read)
        rdata_q <= rx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      bus_rdata <= '0;
      case (bus_addr)
        REG_CTRL: begin
          bus_rdata[EN_BIT]      <= en;
          bus_rdata[DIV_W-1:0]   <= div;
        end
        REG_CMD: begin
          bus_rdata[READY_BIT]   <= !busy;
          bus_rdata[RD_BIT]      <= rd_sel;
          bus_rdata[12:8]        <= regad;
          bus_rdata[4:0]         <= phy;
        end
        REG_WDATA: bus_rdata[15:0] <= wdata_q;
        default:   bus_rdata[15:0] <= rdata_q;
      endcase
    end
  end

  // R4: an accepted initiate drops ready on the next cycle
  p_start_busy_r4: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);
  // R8: command fields hold while a frame is in flight
  p_busy_cmd_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && bus_we && bus_addr == REG_CMD) |=> ($stable(phy) && $stable(regad)));
  // R9: no frame bit leaves while the clock is disabled
  p_pending_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (!en && !mdio_oe) |=> !mdio_oe);
endmodule

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
  localparam int DIV_W = 6;
  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] bus_addr = '0;
  logic bus_we = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic mdc, mdio_o, mdio_oe, mdio_i = 1'b1;

  int checks = 0, failures = 0;
  bit finished = 0;

  mdio_master #(.DIV_W(DIV_W)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference model of the management clock, compared every cycle (R1, R2)
  bit m_en = 0, m_mdc = 0;
  int m_div = 0, m_cnt = 0, mdc_errs = 0;
  always @(posedge clk) begin
    if (rst) begin
      m_en = 0; m_div = 0; m_cnt = 0; m_mdc = 0;
    end else begin
      if (!m_en) begin m_cnt = 0; m_mdc = 0; end
      else if (m_cnt >= m_div) begin m_cnt = 0; m_mdc = !m_mdc; end
      else m_cnt++;
      if (bus_we && bus_addr == 2'd0) begin
        m_en = bus_wdata[16];
        m_div = bus_wdata[DIV_W-1:0];
      end
    end
  end
  always @(negedge clk) if (!rst && !finished) begin
    checks++;
    if (mdc !== m_mdc) begin
      failures++;
      if (mdc_errs < 5) $display("FAIL R1/R2 mdc actual=%0b expected=%0b", mdc, m_mdc);
      mdc_errs++;
    end
  end

  // PHY model: records each rising-edge bit, answers read data
  int phy_cnt = -1;
  logic [63:0] phy_bits, phy_oe;
  logic [15:0] phy_resp = '0;
  always @(posedge mdc) begin
    if (phy_cnt < 0 && mdio_oe) begin
      phy_bits[63] = mdio_o; phy_oe[63] = 1'b1; phy_cnt = 1;
    end else if (phy_cnt >= 0 && phy_cnt < 64) begin
      phy_bits[63-phy_cnt] = mdio_o; phy_oe[63-phy_cnt] = mdio_oe; phy_cnt++;
    end
  end
  always @(negedge mdc) begin
    if (phy_cnt >= 48 && phy_cnt < 64) mdio_i = phy_resp[63-phy_cnt];
    else mdio_i = 1'b1;
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask
  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_we = 1'b0;
    @(negedge clk); d = bus_rdata;
  endtask
  task automatic wait_ready(output bit ok);
    logic [31:0] v;
    ok = 0;
    for (int i = 0; i < 4000; i++) begin
      rd(2'd1, v);
      if (v[17]) begin ok = 1; break; end
    end
  endtask
  function automatic logic [63:0] exp_frame(bit r, logic [4:0] p, logic [4:0] g, logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, r ? 2'b10 : 2'b01, p, g, 2'b10, d};
  endfunction
  task automatic check_frame(bit r, logic [63:0] e, string req);
    logic [63:0] oe_e;
    bit ok;
    oe_e = r ? {{46{1'b1}}, 18'b0} : {64{1'b1}};
    ok = (phy_cnt == 64) && (phy_oe == oe_e) &&
         (r ? (phy_bits[63:18] == e[63:18]) : (phy_bits == e));
    check(ok, req, phy_bits, e);
    check(phy_oe == oe_e, "R6/R7 output enable pattern", phy_oe, oe_e);
  endtask

  initial begin
    logic [31:0] v;
    bit ok;
    int t0, per;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    rd(2'd0, v); check(v == 0, "R10 ctrl after reset", v, 0);
    rd(2'd1, v); check(v[17] == 1'b1, "R10 ready after reset", v[17], 1);
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R10 pins after reset", {mdc, mdio_oe}, 0);
    // R11: divider truncation
    wr(2'd0, 32'h0000_FFFF); rd(2'd0, v);
    check(v == 32'h3F, "R11 divider truncated, enable clear", v, 32'h3F);
    // R2: disabled clock stays low
    repeat (20) @(negedge clk);
    check(mdc == 1'b0, "R2 mdc low while disabled", mdc, 0);
    // R1: period with div=2 is 6 cycles
    wr(2'd0, 32'h0001_0002);
    @(posedge mdc); t0 = $time; @(posedge mdc); per = ($time - t0) / 20;
    check(per == 6, "R1 mdc period div=2", per, 6);
    // R3/R7/R4: write frame, div=0
    wr(2'd0, 32'h0001_0000);
    phy_cnt = -1;
    wr(2'd2, 32'h0000_A5C3);
    wr(2'd1, 32'h0001_0B15);
    rd(2'd1, v); check(v[17] == 1'b0, "R4 ready low after initiate", v[17], 0);
    wait_ready(ok); check(ok, "R4 ready returns", ok, 1);
    check_frame(0, exp_frame(0, 5'h15, 5'h0B, 16'hA5C3), "R3/R7 write frame");
    // R6: read frame
    phy_cnt = -1; phy_resp = 16'h3C96;
    wr(2'd1, 32'h0001_8707);
    wait_ready(ok); check(ok, "R6 read completes", ok, 1);
    check_frame(1, exp_frame(1, 5'h07, 5'h07, 16'h0), "R3/R6 read frame header");
    rd(2'd3, v); check(v == 32'h3C96, "R6 read data captured", v, 32'h3C96);
    // R5 and R8: slow clock, alter write data and command mid-frame
    wr(2'd0, 32'h0001_0005);
    phy_cnt = -1;
    wr(2'd2, 32'h0000_1234);
    wr(2'd1, 32'h0001_1F01);
    wait (phy_cnt >= 2);
    wr(2'd2, 32'h0000_FFFF);
    wr(2'd1, 32'h0001_8A0A);
    wait_ready(ok); check(ok, "R5 frame completes", ok, 1);
    check_frame(0, exp_frame(0, 5'h01, 5'h1F, 16'h1234), "R5/R8 frame unaffected");
    rd(2'd1, v); check(v[15:0] == 16'h1F01, "R8 fields kept", v[15:0], 16'h1F01);
    repeat (300) @(negedge clk);
    check(phy_cnt == 64 && !mdio_oe, "R8 no extra frame", phy_cnt, 64);
    rd(2'd1, v); check(v[17], "R8 ready still high", v[17], 1);
    // R9: pending while disabled
    wr(2'd0, 32'h0000_0001);
    phy_cnt = -1;
    wr(2'd2, 32'h0000_0F0F);
    wr(2'd1, 32'h0001_0203);
    repeat (60) @(negedge clk);
    rd(2'd1, v); check(v[17] == 1'b0, "R9 ready low while pending", v[17], 0);
    check(mdc == 1'b0 && phy_cnt == -1, "R9 no clock while pending", phy_cnt, -1);
    wr(2'd0, 32'h0001_0001);
    wait_ready(ok); check(ok, "R9 completes after enable", ok, 1);
    check_frame(0, exp_frame(0, 5'h03, 5'h02, 16'h0F0F), "R9 pending frame");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 190000);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule